// File: doc/BRIEF.md
# Asymmetric-Step Up/Down Counter

This block is a synchronous binary counter that moves by one fixed amount when counting up and by a different fixed amount when counting down. On each rising clock edge it picks exactly one action by priority. A synchronous clear comes first. A load of an externally supplied preset value comes second. Last comes a step in the direction chosen by the `up` input, and only while `cnt_en` is high. When none of these applies, the count holds.

The count is an unsigned vector and wraps modulo 2^WIDTH in both directions without any explicit limit check. A registered `wrap` flag pulses for one cycle after an enabled step crosses the modular boundary: a carry out of the top bit when counting up, or a borrow when counting down. Typical uses are programmable phase accumulators, credit counters that gain and lose by unequal amounts, and address walkers with different forward and backward strides. WIDTH, UP_STEP and DOWN_STEP are parameters. Both steps must be less than 2^WIDTH.

Top module: `ud_step_counter`

## Requirements
- R1: When `srst` is 1 at a rising edge, `count` becomes 0 and `wrap` becomes 0 after that edge, whatever the values of `load`, `cnt_en` and `up`.
- R2: When `srst` is 0 and `load` is 1 at a rising edge, `count` takes the value of `load_val` and `wrap` becomes 0, whatever the values of `cnt_en` and `up`.
- R3: When `srst`, `load` and `cnt_en` are all 0 at a rising edge, `count` keeps its value and `wrap` becomes 0.
- R4: When `srst` is 0, `load` is 0, `cnt_en` is 1 and `up` is 1 at a rising edge, `count` becomes (count + UP_STEP) mod 2^WIDTH.
- R5: When `srst` is 0, `load` is 0, `cnt_en` is 1 and `up` is 0 at a rising edge, `count` becomes (count − DOWN_STEP) mod 2^WIDTH.
- R6: After an enabled up step, `wrap` is 1 for that cycle exactly when count + UP_STEP ≥ 2^WIDTH; otherwise it is 0.
- R7: After an enabled down step, `wrap` is 1 for that cycle exactly when count < DOWN_STEP; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous clear, active high, highest priority |
| load | input | 1 | Synchronous load of `load_val`, second priority |
| load_val | input | WIDTH | Preset value to load |
| cnt_en | input | 1 | Count enable |
| up | input | 1 | Direction: 1 adds UP_STEP, 0 subtracts DOWN_STEP |
| count | output | WIDTH | Registered count value |
| wrap | output | 1 | Registered one-cycle boundary-crossing pulse |

## Verification
Every result is due one clock after its stimulus. The inputs seen at a rising edge decide `count` and `wrap`, and both outputs are readable from just after that edge until the next one. The bench applies inputs on the falling edge and waits for the following rising edge. It compares both outputs at the next falling edge, against a model advanced once per edge. No check reads a value two edges old or one produced in the same edge it is driven. The bench runs the counter at a narrow width with unequal steps, so random traffic wraps often in both directions.

// File: rtl/ud_cnt_pkg.sv
package ud_cnt_pkg;

  // Action selected for one clock edge, in priority order.
  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_CLEAR = 3'd1,
    ACT_LOAD  = 3'd2,
    ACT_INC   = 3'd3,
    ACT_DEC   = 3'd4
  } cnt_act_e;

endpackage

// File: rtl/ud_cnt_arbiter.sv
module ud_cnt_arbiter
  import ud_cnt_pkg::*;
(
  input  logic     srst,
  input  logic     load,
  input  logic     cnt_en,
  input  logic     up,
  output cnt_act_e act
);

  always_comb begin
    if (srst)        act = ACT_CLEAR;
    else if (load)   act = ACT_LOAD;
    else if (cnt_en) act = up ? ACT_INC : ACT_DEC;
    else             act = ACT_HOLD;
  end

endmodule

// File: rtl/ud_cnt_stepper.sv
module ud_cnt_stepper #(
  parameter int WIDTH     = 12,
  parameter int UP_STEP   = 1,
  parameter int DOWN_STEP = 1
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] inc_val,
  output logic             inc_carry,
  output logic [WIDTH-1:0] dec_val,
  output logic             dec_borrow
);

  localparam logic [WIDTH:0] INC_AMT = (WIDTH+1)'(UP_STEP);
  localparam logic [WIDTH:0] DEC_AMT = (WIDTH+1)'(DOWN_STEP);

  logic [WIDTH:0] sum_ext;
  logic [WIDTH:0] diff_ext;

  // One extra bit catches the carry or borrow across the modular boundary.
  always_comb begin
    sum_ext    = {1'b0, cur} + INC_AMT;
    diff_ext   = {1'b0, cur} - DEC_AMT;
    inc_val    = sum_ext[WIDTH-1:0];
    inc_carry  = sum_ext[WIDTH];
    dec_val    = diff_ext[WIDTH-1:0];
    dec_borrow = diff_ext[WIDTH];
  end

endmodule

// File: rtl/ud_step_counter.sv
module ud_step_counter #(
  parameter int WIDTH     = 12,
  parameter int UP_STEP   = 1,
  parameter int DOWN_STEP = 1
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             cnt_en,
  input  logic             up,
  output logic [WIDTH-1:0] count,
  output logic             wrap
);
  import ud_cnt_pkg::*;

  localparam longint RANGE = longint'(1) << WIDTH;
  localparam logic [WIDTH-1:0] UP_V = WIDTH'(UP_STEP);
  localparam logic [WIDTH-1:0] DN_V = WIDTH'(DOWN_STEP);

  initial begin
    AST_UP_STEP_RANGE: assert (longint'(UP_STEP) < RANGE && UP_STEP >= 0);     // R4
    AST_DN_STEP_RANGE: assert (longint'(DOWN_STEP) < RANGE && DOWN_STEP >= 0); // R5
  end

  cnt_act_e         act;
  logic [WIDTH-1:0] inc_val;
  logic [WIDTH-1:0] dec_val;
  logic             inc_carry;
  logic             dec_borrow;

  ud_cnt_arbiter u_arb (
    .srst   (srst),
    .load   (load),
    .cnt_en (cnt_en),
    .up     (up),
    .act    (act)
  );

  ud_cnt_stepper #(
    .WIDTH     (WIDTH),
    .UP_STEP   (UP_STEP),
    .DOWN_STEP (DOWN_STEP)
  ) u_step (
    .cur        (count),
    .inc_val    (inc_val),
    .inc_carry  (inc_carry),
    .dec_val    (dec_val),
    .dec_borrow (dec_borrow)
  );

  always_ff @(posedge clk) begin
    case (act)
      ACT_CLEAR: begin count <= '0;       wrap <= 1'b0;       end
      ACT_LOAD:  begin count <= load_val; wrap <= 1'b0;       end
      ACT_INC:   begin count <= inc_val;  wrap <= inc_carry;  end
      ACT_DEC:   begin count <= dec_val;  wrap <= dec_borrow; end
      default:   begin count <= count;    wrap <= 1'b0;       end
    endcase
  end

  AST_CLEAR_WINS: assert property (@(posedge clk)
    srst |=> (count == '0) && !wrap); // R1

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (srst)
    load |=> (count == $past(load_val)) && !wrap); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (srst)
    (!load && !cnt_en) |=> $stable(count) && !wrap); // R3

  AST_INC_AMOUNT: assert property (@(posedge clk) disable iff (srst)
    (!load && cnt_en && up) |=> count == WIDTH'($past(count) + UP_V)); // R4

  AST_DEC_AMOUNT: assert property (@(posedge clk) disable iff (srst)
    (!load && cnt_en && !up) |=> count == WIDTH'($past(count) - DN_V)); // R5

  AST_INC_WRAP: assert property (@(posedge clk) disable iff (srst)
    (!load && cnt_en && up) |=> wrap == (count < $past(count))); // R6

  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (srst)
    (!load && cnt_en && !up) |=> wrap == (count > $past(count))); // R7

endmodule

// File: tb/test_ud_step_counter.sv
`timescale 1ns/1ps
module test_ud_step_counter;

  localparam int W   = 8;
  localparam int US  = 5;
  localparam int DS  = 3;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         srst;
  logic         load;
  logic [W-1:0] load_val;
  logic         cnt_en;
  logic         up;
  logic [W-1:0] count;
  logic         wrap;

  int n_tests  = 0;
  int n_failed = 0;
  int exp_cnt  = 0;
  bit exp_wrap = 1'b0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  ud_step_counter #(.WIDTH(W), .UP_STEP(US), .DOWN_STEP(DS)) i_ud_step_counter (
    .clk(clk), .srst(srst), .load(load), .load_val(load_val),
    .cnt_en(cnt_en), .up(up), .count(count), .wrap(wrap)
  );

  function automatic string req_of(bit r, bit l, bit e, bit u, int c);
    if (r) return "R1";
    if (l) return "R2";
    if (!e) return "R3";
    if (u) return (c + US >= MOD) ? "R6" : "R4";
    return (c < DS) ? "R7" : "R5";
  endfunction

  task automatic model(bit r, bit l, int lv, bit e, bit u);
    if (r) begin exp_cnt = 0; exp_wrap = 0; end
    else if (l) begin exp_cnt = lv; exp_wrap = 0; end
    else if (!e) exp_wrap = 0;
    else if (u) begin
      exp_wrap = (exp_cnt + US) >= MOD;
      exp_cnt  = (exp_cnt + US) % MOD;
    end else begin
      exp_wrap = exp_cnt < DS;
      exp_cnt  = (exp_cnt - DS + MOD) % MOD;
    end
  endtask

  // Called at a falling edge; drives, lets one rising edge pass, compares.
  task automatic cyc(bit r, bit l, int lv, bit e, bit u);
    string rq;
    rq = req_of(r, l, e, u, exp_cnt);
    srst = r; load = l; load_val = W'(lv); cnt_en = e; up = u;
    model(r, l, lv, e, u);
    @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (count !== W'(exp_cnt) || wrap !== exp_wrap) begin
      n_failed++;
      $display("FAIL %s: count=%0d wrap=%0b expected count=%0d wrap=%0b",
               rq, count, wrap, exp_cnt, exp_wrap);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_failed++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    srst = 1; load = 0; load_val = '0; cnt_en = 0; up = 0;
    @(negedge clk);
    cyc(1, 0, 0, 0, 0);          // R1 reset state
    cyc(1, 1, 77, 1, 1);         // R1 clear beats load and count
    cyc(0, 1, 255, 0, 0);        // R2 load with enable low
    cyc(0, 0, 0, 0, 1);          // R3 hold
    cyc(0, 0, 0, 1, 1);          // R6 255+5 wraps to 4
    cyc(0, 0, 0, 1, 1);          // R4 4 -> 9, wrap drops
    cyc(0, 1, 1, 1, 0);          // R2 load beats enabled count
    cyc(0, 0, 0, 1, 0);          // R7 1-3 wraps to 254
    cyc(0, 0, 0, 1, 0);          // R5 254 -> 251
    cyc(0, 1, 251, 0, 1);        // R2 load at boundary value
    cyc(0, 0, 0, 1, 1);          // R6 exact 256 -> 0
    cyc(0, 0, 0, 1, 0);          // R7 0-3 -> 253
    cyc(0, 1, 3, 0, 0);          // R2
    cyc(0, 0, 0, 1, 0);          // R5 exact 3 -> 0, no wrap
    cyc(0, 0, 0, 0, 0);          // R3 hold at zero
    for (int i = 0; i < 4000; i++) begin
      bit r, l, e, u;
      r = ($urandom % 50) == 0;
      l = ($urandom % 12) == 0;
      e = ($urandom % 4) != 0;
      u = $urandom % 2;
      cyc(r, l, int'($urandom % MOD), e, u);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
    $finish;
  end

endmodule